// File: doc/BRIEF.md
# Debug Address Breakpoint Match Unit

This block compares one memory request per cycle against four guest debug address slots and a small table of host-priority slots. A request is either an instruction fetch, where the address is the current program counter, or a data access with a start address, a byte size and a read/write select. Each guest slot is configured by two enable bits and a four-bit nibble holding an access-type code and a length code. Together these two ports form the lower enable byte and the upper configuration half of a 32-bit x86-style debug control word.

The unit reports its results one clock after the request strobe. The outputs are:
- a guest hit pulse and a host hit pulse;
- a held per-slot status mask for a DR6-style status register;
- a strobe that tells the surrounding logic to clear the general-detect bit of the control word;
- a silent-hit flag;
- a page-of-interest flag, which marks data accesses that need slow-path handling because a breakpoint sits in the same page.

A resume-flag input suppresses all guest checking. A vendor-mode strap selects whether disabled slots that also match are reported in the status mask.

Top module: `dbg_bp_match`

## Requirements
- R1: After reset, guest_hit, host_hit, gd_clear, silent_hit and page_hit are 0, and bp_status is all zero.
- R2: All results for a request sampled with req_valid=1 appear on the outputs at the next rising clock edge. The pulse outputs (guest_hit, host_hit, gd_clear, silent_hit, page_hit) are 0 in any cycle that does not follow a valid request.
- R3: Guest slot i is enabled when bp_enables[2i] (local) or bp_enables[2i+1] (global) is 1. Its nibble is bp_cfg[4i+3:4i], with the type code in bits [1:0] and the length code in bits [3:2]. These ports correspond to bits 0..7 and 16..31 of the debug control word. The length code maps 00 to 1 byte, 01 to 2 bytes, 10 to 8 bytes and 11 to 4 bytes.
- R4: For a fetch (req_data=0), a slot qualifies only when its type code is 00 and its length code is 00. A qualifying slot matches when its address equals req_addr exactly.
- R5: For a data access, a write (req_write=1) qualifies slots whose type bit 0 is 1. A read qualifies only slots with type code 11.
- R6: A qualifying data slot matches when the ranges overlap: req_addr < slot_addr + length and req_addr + req_size > slot_addr.
- R7: guest_hit is 1 only when at least one slot is both enabled and matched.
- R8: On a guest hit that is not silent, bp_status is replaced by the report mask and gd_clear pulses. With vendor_alt=0 the report mask is matched AND enabled. With vendor_alt=1 it is every matched slot, whether enabled or not. In all other cases bp_status holds its value.
- R9: With vendor_alt=1, a data guest hit with sys_access=1 raises silent_hit and guest_hit, but not gd_clear, and leaves bp_status unchanged. With vendor_alt=0, sys_access has no effect.
- R10: When resume_flag=1, no guest hit occurs, bp_status is unchanged, and guest slots contribute nothing to page_hit.
- R11: For a data access, page_hit is 1 when either of these lies in the same page as req_addr (address bits above PAGE_BITS equal): an enabled guest slot that qualifies under R5, or a valid host entry that qualifies under R5.
- R12: A host entry with host_valid=1 uses the same nibble encoding and the same fetch and data rules (R4 to R6). When any entry matches, host_hit pulses and guest checking is suppressed for that request: guest_hit is 0 and bp_status is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_write | input | 1 | 1 = write, 0 = read (data only) |
| req_addr | input | AW | Program counter or data start address |
| req_size | input | SW | Data access size in bytes |
| resume_flag | input | 1 | Suppresses guest checking |
| sys_access | input | 1 | Access to a system structure |
| vendor_alt | input | 1 | Alternate status reporting mode |
| bp_enables | input | 2*NBP | Local/global enable pair per guest slot |
| bp_cfg | input | 4*NBP | Type/length nibble per guest slot |
| bp_addrs | input | NBP*AW | Guest slot addresses, slot i at [i*AW +: AW] |
| host_valid | input | HN | Host entry valid bits |
| host_cfg | input | 4*HN | Type/length nibble per host entry |
| host_addrs | input | HN*AW | Host entry addresses |
| guest_hit | output | 1 | Guest breakpoint hit pulse |
| host_hit | output | 1 | Host breakpoint hit pulse |
| bp_status | output | NBP | Held per-slot status bits |
| gd_clear | output | 1 | Clear-general-detect strobe |
| silent_hit | output | 1 | Silent guest hit pulse |
| page_hit | output | 1 | Breakpoint in the accessed page |

## Verification
Every result is due exactly one rising edge after the cycle in which req_valid is sampled high. The bench therefore drives each request on a falling edge, compares all six outputs on the following falling edge, and drops req_valid there. This leaves an idle cycle in which the pulse outputs must return to zero while bp_status holds. The held status mask is tracked in the bench across requests, so a request that must leave it untouched (a silent hit, the resume flag, or host priority) is checked against the value left by the last reporting hit.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

  localparam logic [1:0] RW_EXEC   = 2'b00;
  localparam logic [1:0] RW_RDWR   = 2'b11;
  localparam logic [1:0] LEN_BYTE1 = 2'b00;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] rw;
  } bp_nib_t;

  // Non-monotonic length code: 00->1, 01->2, 10->8, 11->4
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b10:   return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

  // Half-open range overlap with one spare bit so sums never wrap
  function automatic logic span_overlap(input logic [64:0] a_lo, input logic [64:0] a_n,
                                        input logic [64:0] b_lo, input logic [64:0] b_n);
    return (a_lo < (b_lo + b_n)) && ((a_lo + a_n) > b_lo);
  endfunction

  function automatic logic data_type_ok(input logic is_write, input logic [1:0] rw);
    return is_write ? rw[0] : (rw == RW_RDWR);
  endfunction

endpackage

// File: rtl/bp_slot_eval.sv
module bp_slot_eval
  import dbg_bp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SW        = 4,
  parameter int PAGE_BITS = 12
) (
  input  logic          is_data,
  input  logic          is_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [SW-1:0] acc_size,
  input  bp_nib_t       nib,
  input  logic [AW-1:0] slot_addr,
  output logic          qual_match,
  output logic          page_near
);

  logic exec_ok;
  logic data_ok;
  logic in_range;
  logic same_page;

  always_comb begin
    exec_ok    = (nib.rw == RW_EXEC) && (nib.len == LEN_BYTE1);
    data_ok    = data_type_ok(is_write, nib.rw);
    in_range   = span_overlap(65'(acc_addr), 65'(acc_size), 65'(slot_addr), 65'(len_bytes(nib.len)));
    same_page  = (acc_addr[AW-1:PAGE_BITS] == slot_addr[AW-1:PAGE_BITS]);
    qual_match = is_data ? (data_ok && in_range) : (exec_ok && (slot_addr == acc_addr));
    page_near  = is_data && data_ok && same_page;
  end

endmodule

// File: rtl/bp_result_reg.sv
module bp_result_reg #(
  parameter int NBP = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           guest_fire,
  input  logic           host_fire,
  input  logic           silent_fire,
  input  logic           page_fire,
  input  logic [NBP-1:0] report_mask,
  output logic           guest_hit,
  output logic           host_hit,
  output logic [NBP-1:0] bp_status,
  output logic           gd_clear,
  output logic           silent_hit,
  output logic           page_hit
);

  logic status_load;
  assign status_load = req_valid && guest_fire && !silent_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guest_hit  <= 1'b0;
      host_hit   <= 1'b0;
      gd_clear   <= 1'b0;
      silent_hit <= 1'b0;
      page_hit   <= 1'b0;
      bp_status  <= '0;
    end else begin
      guest_hit  <= req_valid && guest_fire;
      host_hit   <= req_valid && host_fire;
      gd_clear   <= status_load;
      silent_hit <= req_valid && silent_fire;
      page_hit   <= req_valid && page_fire;
      if (status_load) bp_status <= report_mask;
    end
  end

endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbg_bp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SW        = 4,
  parameter int NBP       = 4,
  parameter int HN        = 2,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_data,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [SW-1:0]     req_size,
  input  logic              resume_flag,
  input  logic              sys_access,
  input  logic              vendor_alt,
  input  logic [2*NBP-1:0]  bp_enables,
  input  logic [4*NBP-1:0]  bp_cfg,
  input  logic [NBP*AW-1:0] bp_addrs,
  input  logic [HN-1:0]     host_valid,
  input  logic [4*HN-1:0]   host_cfg,
  input  logic [HN*AW-1:0]  host_addrs,
  output logic              guest_hit,
  output logic              host_hit,
  output logic [NBP-1:0]    bp_status,
  output logic              gd_clear,
  output logic              silent_hit,
  output logic              page_hit
);

  logic [NBP-1:0] slot_en;
  logic [NBP-1:0] slot_match;
  logic [NBP-1:0] slot_page;
  logic [HN-1:0]  host_match;
  logic [HN-1:0]  host_page;

  // Named internal events
  logic           host_fire;
  logic           guest_active;
  logic           guest_fire;
  logic           silent_fire;
  logic           page_fire;
  logic [NBP-1:0] report_mask;

  for (genvar g = 0; g < NBP; g++) begin : g_guest
    assign slot_en[g] = bp_enables[2*g] | bp_enables[2*g+1];
    bp_slot_eval #(.AW(AW), .SW(SW), .PAGE_BITS(PAGE_BITS)) u_slot (
      .is_data    (req_data),
      .is_write   (req_write),
      .acc_addr   (req_addr),
      .acc_size   (req_size),
      .nib        (bp_nib_t'(bp_cfg[4*g +: 4])),
      .slot_addr  (bp_addrs[g*AW +: AW]),
      .qual_match (slot_match[g]),
      .page_near  (slot_page[g])
    );
  end

  for (genvar h = 0; h < HN; h++) begin : g_host
    bp_slot_eval #(.AW(AW), .SW(SW), .PAGE_BITS(PAGE_BITS)) u_slot (
      .is_data    (req_data),
      .is_write   (req_write),
      .acc_addr   (req_addr),
      .acc_size   (req_size),
      .nib        (bp_nib_t'(host_cfg[4*h +: 4])),
      .slot_addr  (host_addrs[h*AW +: AW]),
      .qual_match (host_match[h]),
      .page_near  (host_page[h])
    );
  end

  always_comb begin
    host_fire    = |(host_valid & host_match);
    guest_active = !resume_flag && !host_fire;
    guest_fire   = guest_active && |(slot_en & slot_match);
    report_mask  = vendor_alt ? slot_match : (slot_match & slot_en);
    silent_fire  = guest_fire && vendor_alt && sys_access && req_data;
    page_fire    = |(host_valid & host_page) || (!resume_flag && |(slot_en & slot_page));
  end

  bp_result_reg #(.NBP(NBP)) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .guest_fire  (guest_fire),
    .host_fire   (host_fire),
    .silent_fire (silent_fire),
    .page_fire   (page_fire),
    .report_mask (report_mask),
    .guest_hit   (guest_hit),
    .host_hit    (host_hit),
    .bp_status   (bp_status),
    .gd_clear    (gd_clear),
    .silent_hit  (silent_hit),
    .page_hit    (page_hit)
  );

endmodule

// File: rtl/dbg_bp_match_chk.sv
module dbg_bp_match_chk #(
  parameter int NBP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             resume_flag,
  input logic             vendor_alt,
  input logic [2*NBP-1:0] bp_enables,
  input logic             guest_hit,
  input logic             host_hit,
  input logic [NBP-1:0]   bp_status,
  input logic             gd_clear,
  input logic             silent_hit,
  input logic             page_hit
);

  logic [NBP-1:0] en_mask;
  for (genvar i = 0; i < NBP; i++) begin : g_en
    assign en_mask[i] = bp_enables[2*i] || bp_enables[2*i+1];
  end

  // R2
  idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !(guest_hit || host_hit || gd_clear || silent_hit || page_hit));

  // R7
  gd_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gd_clear |-> guest_hit);

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gd_clear |-> $stable(bp_status));

  // R8
  default_enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vendor_alt) |=> (!gd_clear || (((bp_status & ~$past(en_mask)) == '0) && (bp_status != '0))));

  // R9
  silent_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    silent_hit |-> (guest_hit && !gd_clear));

  // R9
  default_no_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vendor_alt) |=> !silent_hit);

  // R10
  resume_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resume_flag) |=> !guest_hit);

  // R12
  host_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_hit |-> !guest_hit);

endmodule

bind dbg_bp_match dbg_bp_match_chk #(.NBP(NBP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .resume_flag (resume_flag),
  .vendor_alt  (vendor_alt),
  .bp_enables  (bp_enables),
  .guest_hit   (guest_hit),
  .host_hit    (host_hit),
  .bp_status   (bp_status),
  .gd_clear    (gd_clear),
  .silent_hit  (silent_hit),
  .page_hit    (page_hit)
);

// File: tb/tb_dbg_bp_match.sv
module tb_dbg_bp_match;

  localparam int AW = 32;
  localparam int SW = 4;
  localparam int NBP = 4;
  localparam int HN = 2;
  localparam int PB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_data = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic resume_flag = 1'b0, sys_access = 1'b0, vendor_alt = 1'b0;
  logic [2*NBP-1:0] bp_enables = '0;
  logic [4*NBP-1:0] bp_cfg = '0;
  logic [NBP*AW-1:0] bp_addrs = '0;
  logic [HN-1:0] host_valid = '0;
  logic [4*HN-1:0] host_cfg = '0;
  logic [HN*AW-1:0] host_addrs = '0;
  logic guest_hit, host_hit, gd_clear, silent_hit, page_hit;
  logic [NBP-1:0] bp_status;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [NBP-1:0] exp_status = '0;

  always #4 clk = ~clk;

  dbg_bp_match #(.AW(AW), .SW(SW), .NBP(NBP), .HN(HN), .PAGE_BITS(PB)) dut (.*);

  task automatic check(input string tag, input string name, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, name, act, exp);
    end
  endtask

  // Independent per-slot model: byte-by-byte walk for overlap
  function automatic void slot_model(input bit [3:0] nib, input bit [31:0] sa, input bit dat,
                                     input bit wr, input bit [31:0] a, input int sz,
                                     output bit m, output bit pg);
    int nb;
    bit q;
    case (nib[3:2])
      2'd0: nb = 1;
      2'd1: nb = 2;
      2'd2: nb = 8;
      default: nb = 4;
    endcase
    if (dat) q = wr ? nib[0] : (nib[1:0] == 2'd3);
    else q = (nib == 4'd0);
    m = 0;
    if (q) begin
      if (!dat) m = (sa == a);
      else
        for (int b = 0; b < sz; b++) begin
          longint x = longint'(a) + b;
          if (x >= longint'(sa) && x < longint'(sa) + nb) m = 1;
        end
    end
    pg = q && dat && ((a >> PB) == (sa >> PB));
  endfunction

  task automatic run_req(input string tag);
    bit [NBP-1:0] sm, sp, sen, rep;
    bit [HN-1:0] hm, hp;
    bit e_host, e_fire, e_sil, e_page;
    @(negedge clk);
    req_valid = 1'b1;
    for (int i = 0; i < NBP; i++) begin
      slot_model(bp_cfg[4*i +: 4], bp_addrs[i*AW +: AW], req_data, req_write, req_addr,
                 int'(req_size), sm[i], sp[i]);
      sen[i] = bp_enables[2*i] | bp_enables[2*i+1];
    end
    for (int h = 0; h < HN; h++)
      slot_model(host_cfg[4*h +: 4], host_addrs[h*AW +: AW], req_data, req_write, req_addr,
                 int'(req_size), hm[h], hp[h]);
    e_host = |(host_valid & hm);
    e_fire = !resume_flag && !e_host && |(sen & sm);
    rep = vendor_alt ? sm : (sm & sen);
    e_sil = e_fire && vendor_alt && sys_access && req_data;
    e_page = req_data && (|(host_valid & hp) || (!resume_flag && |(sen & sp)));
    if (e_fire && !e_sil) exp_status = rep;
    @(negedge clk);
    check(tag, "guest_hit R7", guest_hit, e_fire);
    check(tag, "host_hit R12", host_hit, e_host);
    check(tag, "bp_status R8", bp_status, exp_status);
    check(tag, "gd_clear R8", gd_clear, e_fire && !e_sil);
    check(tag, "silent_hit R9", silent_hit, e_sil);
    check(tag, "page_hit R11", page_hit, e_page);
    req_valid = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    check(tag, "pulses R2", {guest_hit, host_hit, gd_clear, silent_hit, page_hit}, 0);
    check(tag, "status hold R2", bp_status, exp_status);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBP; i++) bp_addrs[i*AW +: AW] = 32'h1000 + 16 * i;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "outputs", {guest_hit, host_hit, gd_clear, silent_hit, page_hit}, 0);
    check("R1", "bp_status", bp_status, 0);
    rst_n = 1'b1;
    check_idle("R1");

    // R3 R4: fetch sweep over every nibble, enable pair, slot and vendor mode
    req_data = 0;
    for (int s = 0; s < NBP; s++)
      for (int nib = 0; nib < 16; nib++)
        for (int en = 0; en < 4; en++)
          for (int va = 0; va < 2; va++) begin
            bp_cfg = '0;
            bp_cfg[4*s +: 4] = 4'(nib);
            bp_enables = '0;
            bp_enables[2*s +: 2] = 2'(en);
            vendor_alt = 1'(va);
            req_addr = 32'h1000 + 16 * s;
            run_req("R3 R4 exec");
          end

    // R5 R6: data sweep on slot 1 across type/length codes, sizes and offsets
    req_data = 1;
    bp_cfg = '0;
    for (int nib = 0; nib < 16; nib++)
      for (int wr = 0; wr < 2; wr++)
        for (int off = -10; off <= 10; off++)
          for (int sz = 0; sz < 4; sz++)
            for (int va = 0; va < 2; va++) begin
              bp_cfg[7:4] = 4'(nib);
              bp_enables = 8'b0000_1000;
              req_write = 1'(wr);
              vendor_alt = 1'(va);
              req_size = SW'(1 << sz);
              req_addr = 32'(32'h1010 + off);
              run_req("R5 R6 data");
            end
    check_idle("R2 idle");

    // R9: silent hit in alternate mode leaves status untouched
    bp_cfg = 16'h00D0; bp_enables = 8'h04; req_write = 1; req_size = 4; req_addr = 32'h1010;
    sys_access = 1; vendor_alt = 1;
    run_req("R9 silent");
    vendor_alt = 0;
    run_req("R9 default sys");
    // R10: resume flag
    resume_flag = 1; run_req("R10 resume"); resume_flag = 0;
    // R12: host priority on fetch
    req_data = 0; bp_cfg = '0; bp_enables = 8'h01; req_addr = 32'h1000;
    host_valid = 2'b10; host_cfg = 8'h00; host_addrs = {32'h1000, 32'h5000};
    run_req("R12 host exec");
    host_valid = '0; run_req("R7 guest exec");
    check_idle("R2 idle");

    // Mixed pseudo-random sweep covering R7 R8 R9 R10 R11 R12 together
    for (int n = 0; n < 3000; n++) begin
      bp_cfg = 16'($urandom);
      bp_enables = 8'($urandom);
      for (int i = 0; i < NBP; i++) bp_addrs[i*AW +: AW] = 32'h2FF0 + ($urandom % 40);
      host_valid = 2'($urandom);
      host_cfg = 8'($urandom);
      for (int h = 0; h < HN; h++) host_addrs[h*AW +: AW] = 32'h2FE0 + ($urandom % 64);
      req_data = 1'($urandom);
      req_write = 1'($urandom);
      req_size = SW'(1 << ($urandom % 4));
      req_addr = 32'h2FF0 + ($urandom % 40);
      resume_flag = (($urandom % 6) == 0);
      sys_access = 1'($urandom);
      vendor_alt = 1'($urandom);
      run_req("R7 R8 R9 R10 R11 R12 mix");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule